// File: doc/BRIEF.md
# Two-Channel Packet Interleaving Arbiter

This block merges packet traffic from two application channels into one stream of beats for a link MAC. Each channel offers beats over a valid/ready handshake. A beat carries a data word, start and end-of-packet flags, an error flag and a count of unused bytes. The used bytes always sit in the most significant byte lanes. Any beat may be a partial word, including beats in the middle of a packet. Every beat that leaves the block is tagged with the channel it came from.

Three inputs decide whether a channel may be served:
- a two-bit enable mask;
- a per-channel permission from the receive calendar;
- a force-transmit override that makes the block ignore the calendar permission.

Once a channel is granted at a packet start, it keeps the grant until its end-of-packet beat transfers. At each packet boundary the two channels take turns in round-robin order. A single output register holds each beat until the downstream accepts it. When that register cannot drain, the block withdraws ready from both channels.

Top module: `ilv_arbiter`

## Requirements
- R1: A beat transfers from channel c only in a cycle where in_valid[c] and in_ready[c] are both high. One cycle after the transfer, out_valid is high and the output carries that beat's data, empty count, start and end flags, with out_ch equal to c (0 or 1).
- R2: Bit c of en_mask enables channel c, so a mask value of 1 enables channel 0 only. While en_mask[c] is 0, in_ready[c] stays low and no beat tagged c is produced.
- R3: While force_tx is low, channel c is served only when cal_ok[c] is 1. While force_tx is high, cal_ok has no effect on which channel is served.
- R4: At most one in_ready bit is high in any cycle. After a non-end-of-packet beat of channel c transfers, only channel c may receive ready until its end-of-packet beat transfers.
- R5: When both channels are eligible and requesting at a packet boundary, the channel other than the one that finished the previous packet is served. The first such tie after reset goes to channel 0.
- R6: While out_valid is high and out_ready is low, every output field holds its value and both in_ready bits are low.
- R7: The empty count passes through unchanged on every beat, including mid-packet beats, and the data word is not shifted.
- R8: out_err carries the channel's error input on an end-of-packet beat and is 0 on every other beat.
- R9: A channel may drop in_valid between beats of a packet with no loss of data. During such a gap, the other channel is still not served.
- R10: While the synchronous active-high rst is high, in_ready is 0. After a reset edge, out_valid is 0, no channel is locked, and the round-robin pointer favours channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_mask | input | 2 | Per-channel enable, bit c for channel c |
| cal_ok | input | 2 | Receive-calendar permission per channel |
| force_tx | input | 1 | Ignore cal_ok when high |
| in_valid | input | 2 | Beat offered per channel |
| in_ready | output | 2 | Beat accepted per channel |
| in_data | input | 2*DATA_W | Data word per channel, valid bytes high |
| in_sop | input | 2 | Start of packet per channel |
| in_eop | input | 2 | End of packet per channel |
| in_err | input | 2 | Packet error, sampled on end-of-packet |
| in_empty | input | 2*EMPTY_W | Unused byte count per channel |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | DATA_W | Output data word |
| out_empty | output | EMPTY_W | Output unused byte count |
| out_sop | output | 1 | Output start of packet |
| out_eop | output | 1 | Output end of packet |
| out_err | output | 1 | Output error, end-of-packet beats only |
| out_ch | output | 1 | Source channel of the output beat |

## Verification
The bench builds the block with BYTES=4, which gives a 32-bit word and a two-bit empty count. It sweeps all 32 settings of enable mask, calendar permission and force-transmit against all four valid patterns, so every eligibility case and every round-robin tie is reached. Directed sequences then cover the lock across valid gaps, mid-packet partial words carrying errors that must be masked, and a stalled output register.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef logic ch_t;

    typedef enum logic {
        ARB_OPEN   = 1'b0,
        ARB_LOCKED = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic sop;
        logic eop;
        logic err;
        ch_t  ch;
    } beat_ctl_t;

    function automatic ch_t peer(input ch_t c);
        return ~c;
    endfunction

endpackage

// File: rtl/ilv_elig.sv
module ilv_elig #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] en_mask,
    input  logic [NCH-1:0] cal_ok,
    input  logic           force_tx,
    output logic [NCH-1:0] elig
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign elig[c] = en_mask[c] & (force_tx | cal_ok[c]);
    end
endmodule

// File: rtl/ilv_grant.sv
module ilv_grant
    import ilv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req,
    input  logic       fire,
    input  logic       fire_eop,
    output ch_t        gnt_ch,
    output logic       gnt_any
);
    arb_state_e state;
    ch_t        owner;
    ch_t        last;

    always_comb begin
        gnt_ch  = 1'b0;
        gnt_any = 1'b0;
        if (state == ARB_LOCKED) begin
            gnt_ch  = owner;
            gnt_any = 1'b1;
        end else if (req == 2'b11) begin
            gnt_ch  = peer(last);
            gnt_any = 1'b1;
        end else if (req[0]) begin
            gnt_ch  = 1'b0;
            gnt_any = 1'b1;
        end else if (req[1]) begin
            gnt_ch  = 1'b1;
            gnt_any = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ARB_OPEN;
            owner <= 1'b0;
            last  <= 1'b1;
        end else if (fire) begin
            if (fire_eop) begin
                state <= ARB_OPEN;
                last  <= gnt_ch;
            end else begin
                state <= ARB_LOCKED;
                owner <= gnt_ch;
            end
        end
    end

    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !fire_eop) |=> (gnt_any && gnt_ch == $past(gnt_ch)));
endmodule

// File: rtl/ilv_outreg.sv
module ilv_outreg
    import ilv_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int EMPTY_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [DATA_W-1:0]  ld_data,
    input  logic [EMPTY_W-1:0] ld_empty,
    input  beat_ctl_t          ld_ctl,
    input  logic               out_ready,
    output logic               space,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data,
    output logic [EMPTY_W-1:0] out_empty,
    output beat_ctl_t          out_ctl
);
    assign space = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            out_data  <= ld_data;
            out_empty <= ld_empty;
            out_ctl   <= ld_ctl;
        end
    end

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                      && $stable(out_empty) && $stable(out_ctl)));

    // R10
    reset_idle_chk: assert property (@(posedge clk) rst |=> !out_valid);
endmodule

// File: rtl/ilv_arbiter.sv
module ilv_arbiter
    import ilv_pkg::*;
#(
    parameter int BYTES = 8,
    localparam int DATA_W  = BYTES * 8,
    localparam int EMPTY_W = $clog2(BYTES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [1:0]                    en_mask,
    input  logic [1:0]                    cal_ok,
    input  logic                          force_tx,
    input  logic [1:0]                    in_valid,
    output logic [1:0]                    in_ready,
    input  logic [1:0][DATA_W-1:0]        in_data,
    input  logic [1:0]                    in_sop,
    input  logic [1:0]                    in_eop,
    input  logic [1:0]                    in_err,
    input  logic [1:0][EMPTY_W-1:0]       in_empty,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [DATA_W-1:0]             out_data,
    output logic [EMPTY_W-1:0]            out_empty,
    output logic                          out_sop,
    output logic                          out_eop,
    output logic                          out_err,
    output logic                          out_ch
);
    logic [1:0] elig;
    logic [1:0] req;
    ch_t        gnt_ch;
    logic       gnt_any;
    logic       space;
    logic       fire;
    beat_ctl_t  sel_ctl;
    beat_ctl_t  out_ctl;

    ilv_elig #(.NCH(2)) u_elig (
        .en_mask  (en_mask),
        .cal_ok   (cal_ok),
        .force_tx (force_tx),
        .elig     (elig)
    );

    assign req = in_valid & elig;

    ilv_grant u_grant (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .fire     (fire),
        .fire_eop (in_eop[gnt_ch]),
        .gnt_ch   (gnt_ch),
        .gnt_any  (gnt_any)
    );

    for (genvar c = 0; c < 2; c++) begin : g_rdy
        assign in_ready[c] = !rst && space && gnt_any && (gnt_ch == ch_t'(c)) && elig[c];
    end

    assign fire = |(in_valid & in_ready);

    always_comb begin
        sel_ctl.sop = in_sop[gnt_ch];
        sel_ctl.eop = in_eop[gnt_ch];
        sel_ctl.err = in_err[gnt_ch] & in_eop[gnt_ch];
        sel_ctl.ch  = gnt_ch;
    end

    ilv_outreg #(.DATA_W(DATA_W), .EMPTY_W(EMPTY_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (fire),
        .ld_data   (in_data[gnt_ch]),
        .ld_empty  (in_empty[gnt_ch]),
        .ld_ctl    (sel_ctl),
        .out_ready (out_ready),
        .space     (space),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_empty (out_empty),
        .out_ctl   (out_ctl)
    );

    assign out_sop = out_ctl.sop;
    assign out_eop = out_ctl.eop;
    assign out_err = out_ctl.err;
    assign out_ch  = out_ctl.ch;

    // R4
    one_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_ready));

    // R4
    lock0_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid[0] && in_ready[0] && !in_eop[0]) |=> !in_ready[1]);

    // R4
    lock1_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid[1] && in_ready[1] && !in_eop[1]) |=> !in_ready[0]);

    // R2
    disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_mask[0] |-> !in_ready[0]) and (!en_mask[1] |-> !in_ready[1]));

    // R3
    no_permit_chk: assert property (@(posedge clk) disable iff (rst)
        (!force_tx && !cal_ok[0]) |-> !in_ready[0]);

    // R6
    stall_block_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> (in_ready == 2'b00));

    // R10
    always_comb begin
        if (rst) begin
            reset_ready_chk: assert (in_ready == 2'b00);
        end
    end
endmodule

// File: tb/ilv_arbiter_tb.sv
module ilv_arbiter_tb;
    localparam int BYTES   = 4;
    localparam int DATA_W  = BYTES * 8;
    localparam int EMPTY_W = $clog2(BYTES);
    localparam int BEAT_W  = DATA_W + EMPTY_W + 4;

    logic clk = 1'b0;
    logic rst;
    logic [1:0] en, cal, v, sop, eop, err, rdy;
    logic frc, ordy;
    logic [1:0][DATA_W-1:0]  d;
    logic [1:0][EMPTY_W-1:0] emp;
    logic out_valid, out_sop, out_eop, out_err, out_ch;
    logic [DATA_W-1:0]  out_data;
    logic [EMPTY_W-1:0] out_empty;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic m_locked, m_owner, m_last, m_ov, m_fire, m_g;
    logic [BEAT_W-1:0] m_beat;

    always #10 clk = ~clk;

    ilv_arbiter #(.BYTES(BYTES)) u_dut (
        .clk(clk), .rst(rst), .en_mask(en), .cal_ok(cal), .force_tx(frc),
        .in_valid(v), .in_ready(rdy), .in_data(d), .in_sop(sop), .in_eop(eop),
        .in_err(err), .in_empty(emp), .out_valid(out_valid), .out_ready(ordy),
        .out_data(out_data), .out_empty(out_empty), .out_sop(out_sop),
        .out_eop(out_eop), .out_err(out_err), .out_ch(out_ch)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // one clock step: check ready before the edge, outputs after it
    task automatic cycle(input string tr, input string to);
        logic [1:0] el, rq, er;
        logic g, any, sp, f;
        @(negedge clk);
        el = en & ({2{frc}} | cal);
        rq = v & el;
        sp = !m_ov || ordy;
        g = 1'b0; any = 1'b0;
        if (m_locked) begin g = m_owner; any = 1'b1; end
        else if (rq == 2'b11) begin g = ~m_last; any = 1'b1; end
        else if (rq[0]) begin g = 1'b0; any = 1'b1; end
        else if (rq[1]) begin g = 1'b1; any = 1'b1; end
        er = 2'b00;
        if (any && sp && el[g]) er[g] = 1'b1;
        chk(rdy === er, tr, "in_ready", 64'(rdy), 64'(er));
        f = any && er[g] && v[g];
        m_fire = f; m_g = g;
        @(posedge clk); #1;
        if (f) begin
            m_beat = {d[g], emp[g], sop[g], eop[g], err[g] & eop[g], g};
            m_ov = 1'b1;
            if (eop[g]) begin m_locked = 1'b0; m_last = g; end
            else begin m_locked = 1'b1; m_owner = g; end
        end else if (ordy) begin
            m_ov = 1'b0;
        end
        chk(out_valid === m_ov, to, "out_valid", 64'(out_valid), 64'(m_ov));
        if (m_ov)
            chk({out_data, out_empty, out_sop, out_eop, out_err, out_ch} === m_beat,
                to, "out_beat",
                64'({out_data, out_empty, out_sop, out_eop, out_err, out_ch}), 64'(m_beat));
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        en = 2'b11; cal = 2'b11; frc = 1'b0; v = 2'b11; sop = 2'b11; eop = 2'b11;
        err = 2'b00; emp = '0; d = '0; ordy = 1'b1; rst = 1'b1;
        m_locked = 0; m_owner = 0; m_last = 1; m_ov = 0; m_fire = 0; m_g = 0;
        m_beat = '0;

        // R10: reset holds ready low and output idle
        repeat (3) begin
            @(negedge clk);
            chk(rdy === 2'b00, "R10", "in_ready in reset", 64'(rdy), 0);
            chk(out_valid === 1'b0, "R10", "out_valid in reset", 64'(out_valid), 0);
        end
        @(posedge clk); #1;
        rst = 1'b0;

        // R5: first tie after reset goes to channel 0
        d[0] = 32'hA0A0_0001; d[1] = 32'hB1B1_0001;
        cycle("R5", "R5");
        chk(out_ch === 1'b0, "R5", "first tie channel", 64'(out_ch), 0);

        // R1 R2 R3 R5 R7: sweep of eligibility settings and valid patterns
        for (int cfg = 0; cfg < 32; cfg++) begin
            for (int vp = 0; vp < 4; vp++) begin
                en = cfg[1:0]; cal = cfg[3:2]; frc = cfg[4]; v = vp[1:0];
                sop = 2'b11; eop = 2'b11;
                err = 2'(cfg + vp);
                for (int c = 0; c < 2; c++) begin
                    d[c]   = {8'(cfg), 8'(vp), 8'(c), 8'(cfg * 4 + vp)};
                    emp[c] = EMPTY_W'(cfg + vp + c);
                end
                cycle("R2 R3 R5", "R1 R7");
            end
        end

        // R4 R7 R8 R9: three-beat packet on channel 0 with a valid gap, channel 1 waiting
        en = 2'b11; cal = 2'b00; frc = 1'b1; ordy = 1'b1;
        v = 2'b00;
        repeat (2) cycle("R4", "R1");
        begin
            int idx = 0;
            for (int k = 0; k < 12; k++) begin
                v[0] = (idx < 3) && !(k == 2 || k == 3);
                v[1] = (k >= 1);
                sop[0] = (idx == 0); eop[0] = (idx == 2);
                err[0] = (idx != 0);
                emp[0] = (idx == 1) ? EMPTY_W'(1) : (idx == 2) ? EMPTY_W'(3) : EMPTY_W'(0);
                d[0]   = 32'hC000_0000 | 32'(idx);
                sop[1] = 1'b1; eop[1] = 1'b1; err[1] = 1'b0; emp[1] = '0;
                d[1]   = 32'hD000_0000 | 32'(k);
                cycle("R4 R9", "R7 R8");
                if (m_fire && m_g == 1'b0) idx++;
            end
            chk(idx == 3, "R9", "channel 0 beats delivered", 64'(idx), 3);
        end

        // R6: output stall blocks both channels and holds the beat
        v = 2'b11; sop = 2'b11; eop = 2'b11; err = 2'b01;
        for (int k = 0; k < 7; k++) begin
            ordy = (k >= 4);
            d[0] = 32'hE000_0000 | 32'(k);
            d[1] = 32'hF000_0000 | 32'(k);
            cycle("R6", "R6");
        end

        // R4 R5: two-beat packets on both channels alternate
        ordy = 1'b1; en = 2'b11; frc = 1'b0; cal = 2'b11;
        begin
            logic [1:0] idx2 = 2'b00;
            int eops = 0;
            logic prev_ch = 1'b0;
            for (int k = 0; k < 16; k++) begin
                v = 2'b11;
                for (int c = 0; c < 2; c++) begin
                    sop[c] = !idx2[c]; eop[c] = idx2[c]; err[c] = 1'b1;
                    emp[c] = EMPTY_W'(k + c);
                    d[c]   = {8'h5A, 8'(c), 16'(k)};
                end
                cycle("R4 R5", "R5 R8");
                if (m_fire) begin
                    if (eop[m_g]) begin
                        if (eops > 0)
                            chk(m_g !== prev_ch, "R5", "alternation", 64'(m_g), 64'(~prev_ch));
                        prev_ch = m_g;
                        eops++;
                    end
                    idx2[m_g] = ~idx2[m_g];
                end
            end
        end

        // R2: only channel 0 enabled (mask value 1)
        en = 2'b01; frc = 1'b1; v = 2'b11; sop = 2'b11; eop = 2'b11;
        repeat (4) begin
            cycle("R2", "R2");
            if (out_valid) chk(out_ch === 1'b0, "R2", "disabled channel tag", 64'(out_ch), 0);
        end

        finish_run();
    end
endmodule